// File: doc/BRIEF.md
# Pipelined Trigger Tag Matcher

This block pairs events from a fast front end with the decisions of a slow trigger supervisor. A trigger request raises a busy flag, and a local-trigger pulse clears it. That pulse carries an 8-bit tag, which the block latches. When the converted data word for an event arrives, the block writes it into a pending queue together with the latched tag. Several trigger cycles can be in flight at the same time. A new request may start as soon as the previous local trigger has come back, without waiting for earlier decisions.

Decisions come back in request order, long after their data. Each one carries a tag and an accept/reject flag, and the block compares its tag with the oldest pending entry. An accepted entry with a matching tag goes out on a one-cycle output strobe, carrying its tag and data. A rejected entry is discarded without a trace. A decision whose tag does not match the oldest entry discards that entry and raises a sticky error flag. Conversion and decision traffic are two independent transactions per event, so the block serves front ends whose data are ready before the verdict arrives.

Top module: `tag_match_pipe`

## Requirements
- R1: After reset, `busy`, `backPressure`, `mismatchErr` and `outValid` are all 0, and the pending queue is empty.
- R2: `busy` rises on the clock edge that samples `trigReq` while `busy` is low. It falls on the edge that samples `localTrig`. A `trigReq` seen while `busy` is high has no effect.
- R3: A word accepted on `convValid` is stored with the tag of the most recent `localTrig` pulse. When `localTrig` and `convValid` occur in the same cycle, the tag presented in that cycle is used.
- R4: A decision with `decAccept`=1 whose `decTag` equals the tag of the oldest pending entry removes that entry. One cycle later the block drives `outValid`=1 for one cycle, with the entry's tag on `outTag` and its data on `outData`. Accepted entries leave in arrival order.
- R5: A decision with `decAccept`=0 whose tag equals the oldest entry's tag removes that entry and produces no output.
- R6: A decision whose tag differs from the oldest entry's tag removes that entry and produces no output. It also sets `mismatchErr`, which stays at 1 until reset.
- R7: A decision that arrives while the queue is empty sets `mismatchErr`, produces no output, and leaves the queue unchanged.
- R8: `backPressure` is 1 exactly when DEPTH entries (default 8) are pending. A `convValid` that arrives while `backPressure` is 1 is ignored, and its word never appears at the output.
- R9: A conversion and a decision in the same cycle both take effect. The decision acts on the queue as it stood before that cycle. The new word is stored whenever the queue was not full before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| trigReq | input | 1 | Trigger request pulse |
| localTrig | input | 1 | Local-trigger pulse from the supervisor |
| localTag | input | TAG_W | Tag carried by the local trigger |
| convValid | input | 1 | Converted data word valid |
| convData | input | DATA_W | Converted data word |
| decValid | input | 1 | Decision valid |
| decTag | input | TAG_W | Tag carried by the decision |
| decAccept | input | 1 | 1 = accept, 0 = reject |
| busy | output | 1 | Request outstanding, local trigger not yet returned |
| backPressure | output | 1 | Pending queue full |
| mismatchErr | output | 1 | Sticky tag-mismatch or empty-queue decision error |
| outValid | output | 1 | Accepted event strobe |
| outTag | output | TAG_W | Tag of the accepted event |
| outData | output | DATA_W | Data of the accepted event |

## Verification
A new conversion can be written in the same cycle that a decision retires the oldest entry. That case decides whether the occupancy count and the head pointer stay consistent. The bench provokes it twice: once with two entries pending, and once with the queue empty, where the decision must count as an error while the new word is still kept. A second overlap is a conversion arriving on the same edge as its local trigger. Both cases are judged by the scoreboard: the accepted items must come out later, in order and with the correct tags, and the error flag must take the expected value.

// File: rtl/tag_match_pkg.sv
package tag_match_pkg;

  typedef struct packed {
    logic push;
    logic pop;
    logic emit;
  } tmStrobes_t;

endpackage

// File: rtl/tag_match_datapath.sv
module tag_match_datapath
  import tag_match_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  tmStrobes_t        st,
  input  logic              localTrig,
  input  logic [TAG_W-1:0]  localTag,
  input  logic [DATA_W-1:0] convData,
  output logic [TAG_W-1:0]  headTag,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam bit POW2  = (DEPTH == (1 << PTR_W));

  logic [TAG_W-1:0]  tagMem  [DEPTH];
  logic [DATA_W-1:0] dataMem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr, wrNext, rdNext;
  logic [TAG_W-1:0]  lastTag, pairTag;
  logic [DATA_W-1:0] headData;

  // A tag presented with the local trigger is usable in the same cycle.
  assign pairTag = localTrig ? localTag : lastTag;

  generate
    if (POW2) begin : gWrapNatural
      assign wrNext = wrPtr + 1'b1;
      assign rdNext = rdPtr + 1'b1;
    end else begin : gWrapCompare
      assign wrNext = (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      assign rdNext = (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastTag <= '0;
    end else if (localTrig) begin
      lastTag <= localTag;
    end
  end

  always_ff @(posedge clk) begin
    if (st.push) begin
      tagMem[wrPtr]  <= pairTag;
      dataMem[wrPtr] <= convData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (st.push) wrPtr <= wrNext;
      if (st.pop)  rdPtr <= rdNext;
    end
  end

  assign headTag  = tagMem[rdPtr];
  assign headData = dataMem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outTag   <= '0;
      outData  <= '0;
    end else begin
      outValid <= st.emit;
      if (st.emit) begin
        outTag  <= headTag;
        outData <= headData;
      end
    end
  end

  // Every output strobe retires a queue entry on the previous edge.
  assert_out_from_pop_R4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(st.pop));

  // The read pointer only moves on a retire.
  assert_head_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    !st.pop |=> $stable(rdPtr));

endmodule

// File: rtl/tag_match_control.sv
module tag_match_control
  import tag_match_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigReq,
  input  logic             localTrig,
  input  logic             convValid,
  input  logic             decValid,
  input  logic [TAG_W-1:0] decTag,
  input  logic             decAccept,
  input  logic [TAG_W-1:0] headTag,
  output tmStrobes_t       st,
  output logic             busy,
  output logic             backPressure,
  output logic             mismatchErr
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] count;
  logic             empty, full, tagMatch, badDecision;

  assign empty    = (count == '0);
  assign full     = (count == CNT_W'(DEPTH));
  assign tagMatch = (headTag == decTag);

  assign st.push = convValid & ~full;
  assign st.pop  = decValid & ~empty;
  assign st.emit = st.pop & tagMatch & decAccept;

  assign badDecision  = decValid & (empty | ~tagMatch);
  assign backPressure = full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else begin
      unique case ({st.push, st.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0;
    end else begin
      busy <= (trigReq & ~busy) | (busy & ~localTrig);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mismatchErr <= 1'b0;
    end else if (badDecision) begin
      mismatchErr <= 1'b1;
    end
  end

  assert_busy_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && localTrig) |=> !busy);

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (backPressure && !decValid) |=> backPressure);

  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    mismatchErr |=> mismatchErr);

  assert_simul_count_R9: assert property (@(posedge clk) disable iff (!rstN)
    (convValid && decValid && !empty && !full) |=> $stable(count));

  assert_empty_no_emit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decValid && empty) |=> (!$past(st.emit) && mismatchErr));

endmodule

// File: rtl/tag_match_pipe.sv
module tag_match_pipe
  import tag_match_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trigReq,
  input  logic              localTrig,
  input  logic [TAG_W-1:0]  localTag,
  input  logic              convValid,
  input  logic [DATA_W-1:0] convData,
  input  logic              decValid,
  input  logic [TAG_W-1:0]  decTag,
  input  logic              decAccept,
  output logic              busy,
  output logic              backPressure,
  output logic              mismatchErr,
  output logic              outValid,
  output logic [TAG_W-1:0]  outTag,
  output logic [DATA_W-1:0] outData
);

  tmStrobes_t       strobes;
  logic [TAG_W-1:0] headTag;

  tag_match_control #(.DEPTH(DEPTH), .TAG_W(TAG_W)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .trigReq      (trigReq),
    .localTrig    (localTrig),
    .convValid    (convValid),
    .decValid     (decValid),
    .decTag       (decTag),
    .decAccept    (decAccept),
    .headTag      (headTag),
    .st           (strobes),
    .busy         (busy),
    .backPressure (backPressure),
    .mismatchErr  (mismatchErr)
  );

  tag_match_datapath #(.DEPTH(DEPTH), .TAG_W(TAG_W), .DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .st        (strobes),
    .localTrig (localTrig),
    .localTag  (localTag),
    .convData  (convData),
    .headTag   (headTag),
    .outValid  (outValid),
    .outTag    (outTag),
    .outData   (outData)
  );

endmodule

// File: tb/tag_match_pipe_test.sv
module tag_match_pipe_test;

  typedef struct packed {
    logic [7:0]  tag;
    logic [15:0] data;
  } item_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trigReq = 1'b0, localTrig = 1'b0, convValid = 1'b0;
  logic        decValid = 1'b0, decAccept = 1'b0;
  logic [7:0]  localTag = '0, decTag = '0;
  logic [15:0] convData = '0;
  logic        busy, backPressure, mismatchErr, outValid;
  logic [7:0]  outTag;
  logic [15:0] outData;

  int    vectors = 0;
  int    fails = 0;
  string curReq = "R1";

  item_t pend[$];
  item_t expQ[$];
  logic  mBusy = 1'b0, mErr = 1'b0;
  logic [7:0] mLast = '0;

  always #2 clk = ~clk;

  tag_match_pipe uut (
    .clk(clk), .rstN(rstN), .trigReq(trigReq), .localTrig(localTrig),
    .localTag(localTag), .convValid(convValid), .convData(convData),
    .decValid(decValid), .decTag(decTag), .decAccept(decAccept),
    .busy(busy), .backPressure(backPressure), .mismatchErr(mismatchErr),
    .outValid(outValid), .outTag(outTag), .outData(outData)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Monitor: every output strobe must match the head of the expected stream.
  always @(negedge clk) begin
    if (rstN && outValid) begin
      vectors++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected output: actual %0h/%0h expected none", curReq, outTag, outData);
      end else begin
        item_t e;
        e = expQ.pop_front();
        if (outTag !== e.tag || outData !== e.data) begin
          fails++;
          $display("FAIL %s output: actual %0h/%0h expected %0h/%0h", curReq, outTag, outData, e.tag, e.data);
        end
      end
    end
  end

  // Driver: applies one cycle of stimulus, updates the model, checks flags.
  task automatic step(input bit tr, input bit lt, input logic [7:0] lTag,
                      input bit cv, input logic [15:0] cd,
                      input bit dv, input logic [7:0] dTag, input bit da);
    logic [7:0] pairTag;
    bit wasFull, wasEmpty;
    trigReq = tr; localTrig = lt; localTag = lTag;
    convValid = cv; convData = cd;
    decValid = dv; decTag = dTag; decAccept = da;
    pairTag  = lt ? lTag : mLast;
    if (lt) mLast = lTag;
    wasFull  = (pend.size() == 8);
    wasEmpty = (pend.size() == 0);
    if (dv) begin
      if (wasEmpty) mErr = 1'b1;
      else begin
        item_t h;
        h = pend.pop_front();
        if (h.tag != dTag) mErr = 1'b1;
        else if (da) expQ.push_back(h);
      end
    end
    if (cv && !wasFull) pend.push_back('{tag: pairTag, data: cd});
    mBusy = (tr && !mBusy) || (mBusy && !lt);
    @(posedge clk);
    @(negedge clk);
    trigReq = 0; localTrig = 0; convValid = 0; decValid = 0; decAccept = 0;
    check(curReq, "busy", 32'(busy), 32'(mBusy));
    check(curReq, "backPressure", 32'(backPressure), 32'(pend.size() == 8));
    check(curReq, "mismatchErr", 32'(mismatchErr), 32'(mErr));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 8'h0, 0, 16'h0, 0, 8'h0, 0);
  endtask

  task automatic doReset();
    rstN = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    pend.delete(); expQ.delete();
    mBusy = 0; mErr = 0; mLast = '0;
    @(negedge clk);
    check("R1", "busy", 32'(busy), 32'h0);
    check("R1", "backPressure", 32'(backPressure), 32'h0);
    check("R1", "mismatchErr", 32'(mismatchErr), 32'h0);
    check("R1", "outValid", 32'(outValid), 32'h0);
  endtask

  task automatic drained(input string req);
    idle(2);
    check(req, "expected items left", 32'(expQ.size()), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    curReq = "R1";
    doReset();

    // R2: busy window, repeated request ignored
    curReq = "R2";
    step(1, 0, 8'h00, 0, 16'h0, 0, 8'h0, 0);
    step(1, 0, 8'h00, 0, 16'h0, 0, 8'h0, 0);
    step(0, 1, 8'h11, 0, 16'h0, 0, 8'h0, 0);
    step(0, 0, 8'h00, 0, 16'h0, 0, 8'h0, 0);

    // R3 + R4: overlapping cycles, accepts leave in order
    curReq = "R3";
    step(0, 0, 8'h00, 1, 16'hA001, 0, 8'h0, 0);
    step(1, 0, 8'h00, 0, 16'h0, 0, 8'h0, 0);
    step(0, 1, 8'h12, 1, 16'hA002, 0, 8'h0, 0);
    curReq = "R4";
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h11, 1);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h12, 1);
    drained("R4");

    // R5: reject drops silently, next accept still correct
    curReq = "R5";
    step(1, 1, 8'h20, 1, 16'hB020, 0, 8'h0, 0);
    step(1, 1, 8'h21, 1, 16'hB021, 0, 8'h0, 0);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h20, 0);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h21, 1);
    drained("R5");

    // R6: mismatching tag drops head and sets sticky error
    curReq = "R6";
    step(0, 1, 8'h30, 1, 16'hC030, 0, 8'h0, 0);
    step(0, 1, 8'h32, 1, 16'hC032, 0, 8'h0, 0);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h31, 1);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h32, 1);
    idle(3);
    drained("R6");

    // R7: decision with empty queue
    curReq = "R1";
    doReset();
    curReq = "R7";
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h00, 1);
    idle(1);
    step(0, 1, 8'h40, 1, 16'hD040, 0, 8'h0, 0);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h40, 1);
    drained("R7");

    // R8: fill, overflow push ignored, drain
    curReq = "R1";
    doReset();
    curReq = "R8";
    for (int i = 0; i < 8; i++)
      step(0, 1, 8'(8'h50 + i), 1, 16'(16'hE000 + i), 0, 8'h0, 0);
    step(0, 1, 8'h5F, 1, 16'hEEEE, 0, 8'h0, 0);
    for (int i = 0; i < 8; i++)
      step(0, 0, 8'h00, 0, 16'h0, 1, 8'(8'h50 + i), 1);
    drained("R8");
    check("R8", "mismatchErr after drain", 32'(mismatchErr), 32'h0);

    // R9: conversion and decision in the same cycle
    curReq = "R9";
    step(0, 1, 8'h60, 1, 16'hF060, 0, 8'h0, 0);
    step(0, 1, 8'h61, 1, 16'hF061, 0, 8'h0, 0);
    step(0, 1, 8'h62, 1, 16'hF062, 1, 8'h60, 1);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h61, 1);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h62, 1);
    drained("R9");
    step(0, 1, 8'h70, 1, 16'hF070, 1, 8'h70, 1);
    step(0, 0, 8'h00, 0, 16'h0, 1, 8'h70, 1);
    drained("R9");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule